// File: doc/BRIEF.md
# Multi-Region Pixel Histogram Engine

This block builds a histogram of a pixel stream in an on-chip array of saturating counters. Each accepted pixel is first shifted right by a programmed amount and then reduced to an 8-bit value. Its bin is the top bits of that value, and the number of bits kept depends on the bin-count mode. Up to four rectangular windows of the frame are counted at the same time. All windows share one 256-location counter array, so finer binning leaves fewer windows active.

Two pixel streams reach the block, each with a valid flag, x and y coordinates and a pixel value. One comes from the sensor front end and one from memory, and a control bit picks which stream is counted. Software programs the mode, shift, pixel width, source and window rectangles through a small register port. It reads the counters back through a word-addressed port with one cycle of latency. The port can optionally zero each counter as it reads it. A one-cycle clear request zeroes the whole array by sweeping every address. While the sweep runs, the block reports busy and discards incoming pixels.

Top module: `pix_hist`

## Requirements
- R1: After reset, every register reads 0, busy is low, and every counter reads 0.
- R2: Register 0 is the control word. Bit 0 selects 8-bit pixels (0 selects 10-bit pixels). Bit 1 enables clear-after-read. Bits 3:2 hold the bin mode. Bit 4 selects the source. Bits 7:5 hold the shift. All bits of register 0 above bit 7 read 0.
- R3: The bin value is formed as follows. In 8-bit mode it is pixel[7:0] shifted right by the shift field. In 10-bit mode it is bits 9:2 of the 10-bit pixel shifted right by the shift field.
- R4: Bin mode m (0..3) gives 32<<m bins, and the bin is the top 5+m bits of the 8-bit value. Window r, bin b is counted at address r*(32<<m)+b.
- R5: Modes 0 and 1 count windows 0 to 3, mode 2 counts windows 0 and 1, and mode 3 counts window 0 only. Inactive windows never count.
- R6: Registers 1+2r and 2+2r hold the x range and y range of window r. In each, bits 11:0 are the start and bits 23:12 are the end, and both bounds are inclusive. A pixel increments the counter of every active window that contains it.
- R7: With source 0 only the front-end stream is counted; with source 1 only the memory stream is counted.
- R8: A read strobe in cycle t puts the counter value on rd_data in cycle t+1. rd_data holds its value in any cycle that follows a cycle without a read strobe.
- R9: With clear-after-read set, a location reads 0 after it has been read. With the bit clear, reads do not change the counters.
- R10: A read of a location in the same cycle that the location is incremented returns the value before the increment. With clear-after-read set, that location then holds 1.
- R11: A counter that holds its all-ones value stays there on further increments.
- R12: A clear request while idle raises busy in the next cycle and keeps it high for exactly 256 cycles. It zeroes every counter. Pixels presented in the request cycle or while busy is high are not counted, and a clear request while busy is ignored.
- R13: A pixel presented in cycle t is visible to a read strobed in cycle t+2 or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 24 | Register write data |
| cfg_rdata | output | 24 | Read-back of the addressed register |
| fe_valid | input | 1 | Front-end pixel valid |
| fe_x | input | 12 | Front-end pixel column |
| fe_y | input | 12 | Front-end pixel row |
| fe_pix | input | 10 | Front-end pixel value |
| mem_valid | input | 1 | Memory-stream pixel valid |
| mem_x | input | 12 | Memory-stream pixel column |
| mem_y | input | 12 | Memory-stream pixel row |
| mem_pix | input | 10 | Memory-stream pixel value |
| clear_all | input | 1 | One-cycle request to zero all counters |
| busy | output | 1 | High while the clear sweep runs |
| rd_en | input | 1 | Counter read strobe |
| rd_addr | input | 8 | Counter address |
| rd_data | output | CNT_W | Counter value, one cycle after the strobe |

## Verification
A wrong bin, window or address calculation stays hidden in the counter array until that location is read. After every stimulus pattern the bench reads all 256 locations and compares each one with a behavioural model every cycle, so any such error shows within one readout pass. Errors in the sweep sequencing or the busy flag appear at the busy port in the cycle they occur. Errors in the read pipeline appear on rd_data one cycle after the affected strobe.

// File: rtl/hist_pkg.sv
// Shared sizes and types for the pixel histogram.
// Assumes four windows sharing a 256-location counter array.
package hist_pkg;
    parameter int COORD_W      = 12;
    parameter int CFG_W        = 2 * COORD_W;
    parameter int NREG         = 4;
    parameter int LOCS_PER_REG = 64;
    parameter int MEM_DEPTH    = NREG * LOCS_PER_REG;
    parameter int MEM_AW       = $clog2(MEM_DEPTH);

    // Control word, packed so that bit 0 is the pixel-width select.
    typedef struct packed {
        logic [2:0] shift;
        logic       src;
        logic [1:0] mode;
        logic       clr_rd;
        logic       dsize8;
    } hist_ctrl_t;

    localparam int CTRL_W = $bits(hist_ctrl_t);

    typedef struct packed {
        logic [COORD_W-1:0] x_hi;
        logic [COORD_W-1:0] x_lo;
        logic [COORD_W-1:0] y_hi;
        logic [COORD_W-1:0] y_lo;
    } hist_rect_t;

    // Mask of windows that may count in a given bin mode.
    function automatic logic [NREG-1:0] region_enable(input logic [1:0] mode);
        int n;
        n = (mode < 2'd2) ? 4 : ((mode == 2'd2) ? 2 : 1);
        return NREG'((1 << n) - 1);
    endfunction
endpackage

// File: rtl/hist_cfg_regs.sv
// Control and window-rectangle registers with combinational read-back.
// Assumes register 0 is control, registers 1+2r / 2+2r hold window r's
// x and y ranges; unmapped addresses read 0.
module hist_cfg_regs
    import hist_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             addr,
    input  logic [CFG_W-1:0]          wdata,
    output logic [CFG_W-1:0]          rdata,
    output hist_ctrl_t                ctrl,
    output hist_rect_t [NREG-1:0]     rects
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CFG_W-1:0]  xr_q [NREG];
    logic [CFG_W-1:0]  yr_q [NREG];

    // Register writes, all fields cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            for (int r = 0; r < NREG; r++) begin
                xr_q[r] <= '0;
                yr_q[r] <= '0;
            end
        end else if (we) begin
            if (addr == '0) ctrl_q <= wdata[CTRL_W-1:0];
            for (int r = 0; r < NREG; r++) begin
                if (addr == AW'(1 + 2 * r)) xr_q[r] <= wdata;
                if (addr == AW'(2 + 2 * r)) yr_q[r] <= wdata;
            end
        end
    end

    assign ctrl = hist_ctrl_t'(ctrl_q);

    for (genvar g = 0; g < NREG; g++) begin : g_rect
        assign rects[g].x_lo = xr_q[g][COORD_W-1:0];
        assign rects[g].x_hi = xr_q[g][CFG_W-1:COORD_W];
        assign rects[g].y_lo = yr_q[g][COORD_W-1:0];
        assign rects[g].y_hi = yr_q[g][CFG_W-1:COORD_W];
    end

    // Read-back mux; reserved control bits return zero.
    always_comb begin
        rdata = '0;
        if (addr == '0) rdata = CFG_W'(ctrl_q);
        for (int r = 0; r < NREG; r++) begin
            if (addr == AW'(1 + 2 * r)) rdata = xr_q[r];
            if (addr == AW'(2 + 2 * r)) rdata = yr_q[r];
        end
    end
endmodule

// File: rtl/hist_bin_map.sv
// Turns one pixel into a bin and, per window, a hit flag and counter address.
// Purely combinational; assumes PIX_W >= 8.
module hist_bin_map
    import hist_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  hist_ctrl_t                    ctrl,
    input  hist_rect_t [NREG-1:0]         rects,
    input  logic [PIX_W-1:0]              pix,
    input  logic [COORD_W-1:0]            x,
    input  logic [COORD_W-1:0]            y,
    output logic [NREG-1:0]               hit,
    output logic [NREG-1:0][MEM_AW-1:0]   addr
);
    localparam int VAL_W = 8;

    logic [PIX_W-1:0] shifted;
    logic [VAL_W-1:0] val8;
    logic [VAL_W-1:0] bin;
    logic [NREG-1:0]  en;

    // Scale the pixel to 8 bits and keep the top bits for the bin.
    always_comb begin
        shifted = pix >> ctrl.shift;
        val8    = ctrl.dsize8 ? (pix[VAL_W-1:0] >> ctrl.shift)
                              : shifted[PIX_W-1 -: VAL_W];
        bin     = val8 >> (2'd3 - ctrl.mode);
        en      = region_enable(ctrl.mode);
    end

    // Window containment and address per window.
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            hit[r]  = en[r]
                   && (x >= rects[r].x_lo) && (x <= rects[r].x_hi)
                   && (y >= rects[r].y_lo) && (y <= rects[r].y_hi);
            addr[r] = MEM_AW'((r << (5 + int'(ctrl.mode))) + int'(bin));
        end
    end
endmodule

// File: rtl/hist_counter_mem.sv
// Saturating counter array with up to NREG increments per cycle, a read port
// with optional clear, and a sweeping clear of the whole array.
// Assumes increment addresses of different windows never coincide.
module hist_counter_mem
    import hist_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inc_valid,
    input  logic [NREG-1:0]               inc_hit,
    input  logic [NREG-1:0][MEM_AW-1:0]   inc_addr,
    input  logic                          clr_rd,
    input  logic                          clear_all,
    output logic                          busy,
    input  logic                          rd_en,
    input  logic [MEM_AW-1:0]             rd_addr,
    output logic [CNT_W-1:0]              rd_data
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [MEM_AW-1:0] LAST   = MEM_AW'(MEM_DEPTH - 1);

    logic [CNT_W-1:0]  cnt_q [MEM_DEPTH];
    logic [CNT_W-1:0]  cnt_d [MEM_DEPTH];
    logic [MEM_AW-1:0] sweep_idx;

    // Next value per location: clears first, then a saturating increment.
    always_comb begin
        for (int a = 0; a < MEM_DEPTH; a++) begin
            logic [CNT_W-1:0] base;
            logic             bump;
            base = cnt_q[a];
            if (busy && sweep_idx == MEM_AW'(a)) base = '0;
            if (rd_en && clr_rd && rd_addr == MEM_AW'(a)) base = '0;
            bump = 1'b0;
            for (int r = 0; r < NREG; r++) begin
                if (inc_valid && inc_hit[r] && inc_addr[r] == MEM_AW'(a)) bump = 1'b1;
            end
            cnt_d[a] = (bump && base != CNT_MAX) ? base + 1'b1 : base;
        end
    end

    // Counter storage.
    always_ff @(posedge clk) begin
        for (int a = 0; a < MEM_DEPTH; a++) begin
            if (!rst_n) cnt_q[a] <= '0;
            else        cnt_q[a] <= cnt_d[a];
        end
    end

    // Clear sweep sequencer: one location per cycle while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            sweep_idx <= '0;
        end else if (busy) begin
            sweep_idx <= sweep_idx + 1'b1;
            if (sweep_idx == LAST) busy <= 1'b0;
        end else if (clear_all) begin
            busy      <= 1'b1;
            sweep_idx <= '0;
        end
    end

    // Registered read port returning the pre-update value.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= cnt_q[rd_addr];
    end
endmodule

// File: rtl/pix_hist.sv
// Top of the multi-window pixel histogram: source select, one capture stage
// that freezes bin and window hits, then the shared counter array.
// Assumes the control fields are stable while a frame is being counted.
module pix_hist
    import hist_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int CNT_W  = 20,
    parameter int CFG_AW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    input  logic                 fe_valid,
    input  logic [COORD_W-1:0]   fe_x,
    input  logic [COORD_W-1:0]   fe_y,
    input  logic [PIX_W-1:0]     fe_pix,
    input  logic                 mem_valid,
    input  logic [COORD_W-1:0]   mem_x,
    input  logic [COORD_W-1:0]   mem_y,
    input  logic [PIX_W-1:0]     mem_pix,
    input  logic                 clear_all,
    output logic                 busy,
    input  logic                 rd_en,
    input  logic [MEM_AW-1:0]    rd_addr,
    output logic [CNT_W-1:0]     rd_data
);
    hist_ctrl_t                   ctrl;
    hist_rect_t [NREG-1:0]        rects;
    logic                         sel_valid;
    logic [COORD_W-1:0]           sel_x;
    logic [COORD_W-1:0]           sel_y;
    logic [PIX_W-1:0]             sel_pix;
    logic [NREG-1:0]              map_hit;
    logic [NREG-1:0][MEM_AW-1:0]  map_addr;
    logic                         st_valid;
    logic [NREG-1:0]              st_hit;
    logic [NREG-1:0][MEM_AW-1:0]  st_addr;

    hist_cfg_regs #(.AW(CFG_AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .ctrl  (ctrl),
        .rects (rects)
    );

    // Pick the stream named by the source bit.
    always_comb begin
        sel_valid = ctrl.src ? mem_valid : fe_valid;
        sel_x     = ctrl.src ? mem_x     : fe_x;
        sel_y     = ctrl.src ? mem_y     : fe_y;
        sel_pix   = ctrl.src ? mem_pix   : fe_pix;
    end

    hist_bin_map #(.PIX_W(PIX_W)) u_map (
        .ctrl  (ctrl),
        .rects (rects),
        .pix   (sel_pix),
        .x     (sel_x),
        .y     (sel_y),
        .hit   (map_hit),
        .addr  (map_addr)
    );

    // Capture stage; pixels are dropped while a clear is requested or running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_hit   <= '0;
            st_addr  <= '0;
        end else begin
            st_valid <= sel_valid && !busy && !clear_all;
            st_hit   <= map_hit;
            st_addr  <= map_addr;
        end
    end

    hist_counter_mem #(.CNT_W(CNT_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_valid (st_valid),
        .inc_hit   (st_hit),
        .inc_addr  (st_addr),
        .clr_rd    (ctrl.clr_rd),
        .clear_all (clear_all),
        .busy      (busy),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/hist_check.sv
// Protocol checks for pix_hist, attached with bind below.
module hist_check
    import hist_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int CFG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_all,
    input logic              busy,
    input logic              rd_en,
    input logic [CNT_W-1:0]  rd_data,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic              st_valid,
    input logic [NREG-1:0]   st_hit,
    input hist_ctrl_t        ctrl
);
    logic [MEM_AW:0] busy_cnt;

    // Length of the current busy period.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all && !busy |=> busy);
    p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && busy_cnt < (MEM_AW+1)'(MEM_DEPTH - 1) |=> busy);
    p_busy_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && busy_cnt == (MEM_AW+1)'(MEM_DEPTH - 1) |=> !busy);
    p_drop_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !st_valid);
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr == '0 |-> cfg_rdata[CFG_W-1:CTRL_W] == '0);
    p_active_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_hit & ~region_enable($past(ctrl.mode))) == '0);
endmodule

bind pix_hist hist_check #(.CNT_W(CNT_W), .CFG_AW(CFG_AW)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (clear_all),
    .busy      (busy),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .st_valid  (st_valid),
    .st_hit    (st_hit),
    .ctrl      (ctrl)
);

// File: tb/test_pix_hist.sv
module test_pix_hist;
    import hist_pkg::*;

    localparam int CW    = 8;
    localparam int MAXC  = 255;
    localparam int DEPTH = 256;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [3:0]         cfg_addr = '0;
    logic [23:0]        cfg_wdata = '0;
    logic [23:0]        cfg_rdata;
    logic               fe_valid = 1'b0, mem_valid = 1'b0;
    logic [11:0]        fe_x = '0, fe_y = '0, mem_x = '0, mem_y = '0;
    logic [9:0]         fe_pix = '0, mem_pix = '0;
    logic               clear_all = 1'b0;
    logic               busy;
    logic               rd_en = 1'b0;
    logic [7:0]         rd_addr = '0;
    logic [CW-1:0]      rd_data;

    pix_hist #(.PIX_W(10), .CNT_W(CW), .CFG_AW(4)) i_pix_hist (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fe_valid(fe_valid), .fe_x(fe_x), .fe_y(fe_y), .fe_pix(fe_pix),
        .mem_valid(mem_valid), .mem_x(mem_x), .mem_y(mem_y), .mem_pix(mem_pix),
        .clear_all(clear_all), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    // Reference model state.
    int    m_cnt [DEPTH];
    int    m_ctrl, m_busy, m_idx, m_rd, m_stv;
    int    m_xr [4];
    int    m_yr [4];
    int    m_sth [4];
    int    m_sta [4];
    int    started = 0;
    int    nvec = 0, nfail = 0;
    string cur_req = "R1";

    function automatic int model_rdata(int a);
        if (a == 0) return m_ctrl;
        if (a >= 1 && a <= 8) return ((a - 1) % 2 == 0) ? m_xr[(a - 1) / 2] : m_yr[(a - 1) / 2];
        return 0;
    endfunction

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin : model
        int busy_old, c, sh, md, ds, v, bin, nact, p, x, y, vld, x0, x1, y0, y1;
        started = 1;
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) m_cnt[a] = 0;
            for (int r = 0; r < 4; r++) begin m_xr[r] = 0; m_yr[r] = 0; m_sth[r] = 0; m_sta[r] = 0; end
            m_ctrl = 0; m_busy = 0; m_idx = 0; m_rd = 0; m_stv = 0;
        end else begin
            busy_old = m_busy;
            c = m_ctrl;
            if (rd_en) begin
                m_rd = m_cnt[rd_addr];
                if ((c >> 1) & 1) m_cnt[rd_addr] = 0;
            end
            if (busy_old != 0) begin
                m_cnt[m_idx] = 0;
                m_idx++;
                if (m_idx == DEPTH) m_busy = 0;
            end
            if (m_stv != 0)
                for (int r = 0; r < 4; r++)
                    if (m_sth[r] != 0 && m_cnt[m_sta[r]] < MAXC) m_cnt[m_sta[r]]++;
            if (clear_all && busy_old == 0) begin m_busy = 1; m_idx = 0; end
            sh = (c >> 5) & 7; md = (c >> 2) & 3; ds = c & 1;
            if ((c >> 4) & 1) begin vld = mem_valid; p = mem_pix; x = mem_x; y = mem_y; end
            else              begin vld = fe_valid;  p = fe_pix;  x = fe_x;  y = fe_y;  end
            v    = (ds != 0) ? ((p & 255) >> sh) : (((p >> sh) >> 2) & 255);
            bin  = v >> (3 - md);
            nact = (md < 2) ? 4 : ((md == 2) ? 2 : 1);
            m_stv = (vld != 0 && busy_old == 0 && !clear_all) ? 1 : 0;
            for (int r = 0; r < 4; r++) begin
                x0 = m_xr[r] & 4095; x1 = (m_xr[r] >> 12) & 4095;
                y0 = m_yr[r] & 4095; y1 = (m_yr[r] >> 12) & 4095;
                m_sth[r] = (r < nact && x >= x0 && x <= x1 && y >= y0 && y <= y1) ? 1 : 0;
                m_sta[r] = (r * (32 << md) + bin) & 255;
            end
            if (cfg_we) begin
                if (cfg_addr == 0) m_ctrl = cfg_wdata & 255;
                else if (cfg_addr <= 8) begin
                    if ((cfg_addr - 1) % 2 == 0) m_xr[(cfg_addr - 1) / 2] = cfg_wdata;
                    else                         m_yr[(cfg_addr - 1) / 2] = cfg_wdata;
                end
            end
        end
    end

    // Compare all outputs with the model, away from the rising edge.
    always @(negedge clk) begin
        if (started != 0) begin
            nvec++;
            if (int'(rd_data) != m_rd) begin
                nfail++;
                $display("FAIL %s rd_data got %0d exp %0d", cur_req, rd_data, m_rd);
            end
            if (int'(busy) != m_busy) begin
                nfail++;
                $display("FAIL %s busy got %0d exp %0d", cur_req, busy, m_busy);
            end
            if (int'(cfg_rdata) != model_rdata(int'(cfg_addr))) begin
                nfail++;
                $display("FAIL %s cfg_rdata got %0h exp %0h", cur_req, cfg_rdata,
                         model_rdata(int'(cfg_addr)));
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        cfg_we = 0; fe_valid = 0; mem_valid = 0; clear_all = 0; rd_en = 0;
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 24'(d); tick();
    endtask

    task automatic px(input int src, input int x, input int y, input int p);
        if (src != 0) begin mem_valid = 1; mem_x = 12'(x); mem_y = 12'(y); mem_pix = 10'(p); end
        else          begin fe_valid = 1;  fe_x = 12'(x);  fe_y = 12'(y);  fe_pix = 10'(p);  end
        tick();
    endtask

    task automatic rd(input int a);
        rd_en = 1; rd_addr = 8'(a); tick();
    endtask

    task automatic read_all();
        tick(); tick();
        for (int a = 0; a < DEPTH; a++) rd(a);
        tick();
    endtask

    function automatic int ctl(int sh, int src, int md, int clr, int ds);
        return (sh << 5) | (src << 4) | (md << 2) | (clr << 1) | ds;
    endfunction

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state of registers, busy and counters.
        cur_req = "R1";
        for (int a = 0; a < 10; a++) begin cfg_addr = 4'(a); tick(); end
        read_all();
        // R2: control read-back with reserved bits zero.
        cur_req = "R2";
        wr(0, 24'hFFFFFF);
        cfg_addr = 0; tick();
        wr(0, 0);
        // Window rectangles (R6 inclusive bounds).
        wr(1, 0   | (15 << 12)); wr(2, 0 | (3 << 12));
        wr(3, 8   | (31 << 12)); wr(4, 2 | (5 << 12));
        wr(5, 20  | (39 << 12)); wr(6, 0 | (1 << 12));
        wr(7, 0   | (39 << 12)); wr(8, 3 | (5 << 12));
        for (int a = 0; a < 10; a++) begin cfg_addr = 4'(a); tick(); end
        cfg_addr = 0;
        // R3/R4/R5/R6/R9: every mode, both widths, varied shifts, clearing readout.
        cur_req = "R3/R4/R5/R6/R9";
        for (int md = 0; md < 4; md++)
            for (int ds = 0; ds < 2; ds++) begin
                wr(0, ctl((md * 2 + ds * 3) % 8, 0, md, 1, ds));
                for (int i = 0; i < 48; i++)
                    px(0, (i * 7) % 41, i % 6, (i * 37 + md * 11 + ds * 5) % 1024);
                read_all();
                read_all();
            end
        // R7: both streams active with different data.
        cur_req = "R7";
        for (int s = 0; s < 2; s++) begin
            wr(0, ctl(0, s, 1, 1, 0));
            for (int i = 0; i < 40; i++) begin
                fe_valid  = (i % 3 != 0); fe_x = 12'(i % 40); fe_y = 12'(i % 5); fe_pix = 10'(i * 23);
                mem_valid = (i % 4 != 1); mem_x = 12'((i * 3) % 40); mem_y = 12'(i % 6); mem_pix = 10'(1023 - i * 19);
                tick();
            end
            read_all();
        end
        // R9: reads without clear leave counters intact.
        cur_req = "R9";
        wr(0, ctl(0, 0, 0, 0, 1));
        for (int i = 0; i < 10; i++) px(0, 2, 1, 40 + i);
        read_all();
        read_all();
        // R10 and R13: read colliding with an increment, then after it lands.
        cur_req = "R10/R13";
        wr(0, ctl(0, 0, 0, 1, 1));
        px(0, 1, 1, 64); px(0, 1, 1, 64);
        px(0, 1, 1, 64); rd(8); rd(8); rd(8);
        px(0, 1, 1, 64); tick(); rd(8); rd(8);
        wr(0, ctl(0, 0, 0, 0, 1));
        px(0, 1, 1, 64); rd(8); rd(8);
        // R11: saturation.
        cur_req = "R11";
        wr(0, ctl(0, 0, 3, 0, 1));
        for (int i = 0; i < 300; i++) px(0, 0, 0, 5);
        tick(); tick(); rd(5); rd(5);
        // R12: sweeping clear with pixels and repeat requests while busy.
        cur_req = "R12";
        wr(0, ctl(1, 0, 0, 0, 0));
        for (int i = 0; i < 30; i++) px(0, i % 40, i % 6, i * 31);
        fe_valid = 1; fe_x = 3; fe_y = 1; fe_pix = 200; clear_all = 1; tick();
        for (int i = 0; i < 40; i++) begin
            fe_valid = 1; fe_x = 12'(i % 40); fe_y = 12'(i % 6); fe_pix = 10'(i * 13);
            clear_all = (i == 17); rd_en = (i % 5 == 0); rd_addr = 8'(i);
            tick();
        end
        repeat (230) tick();
        read_all();
        px(0, 3, 1, 200);
        read_all();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule